// File: doc/BRIEF.md
# SIMD Lane Shift-Left-and-Insert Unit

This datapath unit carries out a lane-wise shift-left-and-insert on one or two 64-bit vector registers. A 7-bit control word, made of a size bit on top of a 6-bit immediate, selects both the lane width and the shift distance. The position of the highest set bit in the word picks the width, and the bits below that position give the shift. Each lane of the source operand is shifted left, and source bits that leave the top of a lane are dropped. The shifted bits then overwrite the destination lane from the shift point upward. Destination bits below the shift point survive.

A quad-select input chooses between one register (the low 64 bits) and the full 128 bits. In the single-register case the upper half of the result repeats the incoming destination. Two conditions block the write. A control word whose upper four bits are all zero does not belong to this operation. A quad request whose destination or source register index is odd is undefined. The surrounding pipeline presents an operand pair with an input strobe. One cycle later the unit returns the registered result, a write enable and the two refusal flags. The register file and the enabling of the SIMD unit are handled outside.

Top module: `simd_sli_unit`

## Requirements
- R1: The control word `ctrl_field[6:0]` is decoded by its highest set bit. Bit 6 set gives 64-bit lanes with shift `ctrl_field[5:0]`. Pattern 01xxxxx gives 32-bit lanes with shift `ctrl_field[4:0]`. Pattern 001xxxx gives 16-bit lanes with shift `ctrl_field[3:0]`. Pattern 0001xxx gives 8-bit lanes with shift `ctrl_field[2:0]`.
- R2: When `ctrl_field[6:3]` is 0000, `not_op_flag` is 1, `wr_en` is 0 and `result` equals the incoming `dst_old`.
- R3: Each processed lane of `result` equals (old lane AND NOT mask) OR (source lane << shift), where mask is all ones of the lane width shifted left by the shift.
- R4: Source bits shifted past the top of a lane are discarded and never reach the lane above.
- R5: A shift of 0 makes each processed lane equal to the source lane.
- R6: With `quad_sel` = 0, only bits 63:0 are processed and `result[127:64]` equals `dst_old[127:64]`. With `quad_sel` = 1, all 128 bits are processed.
- R7: With `quad_sel` = 1 and either `dst_idx_lsb` or `src_idx_lsb` at 1, and a valid pattern, `undef_flag` is 1, `wr_en` is 0 and `result` equals `dst_old`. `undef_flag` is never raised together with `not_op_flag`.
- R8: The outputs are registered one cycle after `in_valid`. `out_valid` follows `in_valid` with a delay of one cycle. The flags and `wr_en` are 0 whenever `out_valid` is 0.
- R9: `wr_en` is `out_valid` AND NOT `undef_flag` AND NOT `not_op_flag`.
- R10: While reset is asserted, `out_valid`, `wr_en`, both flags and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and control are presented this cycle |
| ctrl_field | input | 7 | Size bit (6) over 6-bit immediate (5:0) |
| quad_sel | input | 1 | 1: process 128 bits, 0: process bits 63:0 |
| dst_idx_lsb | input | 1 | Bit 0 of the destination register index |
| src_idx_lsb | input | 1 | Bit 0 of the source register index |
| src_opnd | input | 128 | Source operand |
| dst_old | input | 128 | Current destination contents |
| out_valid | output | 1 | Result registered from an accepted operation |
| result | output | 128 | Merged destination value |
| wr_en | output | 1 | Destination may be written |
| undef_flag | output | 1 | Quad request with an odd register index |
| not_op_flag | output | 1 | Control word does not encode this operation |

## Verification
The assertions assume that `in_valid` is held low during reset, so the first sampled history is clean. They also assume that the inputs are stable around each rising edge. The upper-half and zero-shift properties assume nothing about operand values. The lane-width properties rely on the decoder keeping every shift below the lane width, which the control field guarantees for any value. The bench drives inputs only on falling edges, lowers `in_valid` between operations, and draws control words from the whole 7-bit space. Random operations therefore also cover the refused patterns and odd register indices, alongside the directed cases at shift 0 and at the largest shift for each width.

// File: rtl/sli_pkg.sv
package sli_pkg;
    localparam int REG_W    = 64;
    localparam int N_REGS   = 2;
    localparam int DATA_W   = REG_W * N_REGS;
    localparam int CTRL_W   = 7;
    localparam int SHAMT_W  = CTRL_W - 1;
    localparam int N_SIZES  = 4;
    localparam int MIN_LANE = 8;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_sz_e;

    typedef struct packed {
        lane_sz_e           size;
        logic [SHAMT_W-1:0] shamt;
        logic               not_op;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic              wr_en;
        logic              undef;
        logic              not_op;
    } out_t;
endpackage

// File: rtl/sli_decode.sv
module sli_decode
    import sli_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output dec_t              dec
);
    always_comb begin
        dec = '{size: LANE_8, shamt: '0, not_op: 1'b0};
        casez (ctrl)
            7'b1??????: begin
                dec.size  = LANE_64;
                dec.shamt = ctrl[5:0];
            end
            7'b01?????: begin
                dec.size  = LANE_32;
                dec.shamt = {1'b0, ctrl[4:0]};
            end
            7'b001????: begin
                dec.size  = LANE_16;
                dec.shamt = {2'b0, ctrl[3:0]};
            end
            7'b0001???: begin
                dec.size  = LANE_8;
                dec.shamt = {3'b0, ctrl[2:0]};
            end
            default: begin
                dec.not_op = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sli_reg_merge.sv
module sli_reg_merge
    import sli_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0]       src,
    input  logic [W-1:0]       dst,
    input  lane_sz_e           size,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [W-1:0]       res
);
    logic [N_SIZES-1:0][W-1:0] cand;

    for (genvar k = 0; k < N_SIZES; k++) begin : g_size
        localparam int LW = MIN_LANE << k;
        localparam int NL = W / LW;
        for (genvar j = 0; j < NL; j++) begin : g_lane
            logic [LW-1:0] s_l, d_l, m_l;
            assign s_l = src[j*LW +: LW];
            assign d_l = dst[j*LW +: LW];
            assign m_l = {LW{1'b1}} << shamt;
            assign cand[k][j*LW +: LW] = (d_l & ~m_l) | (s_l << shamt);
        end
    end

    assign res = cand[size];
endmodule

// File: rtl/simd_sli_unit.sv
module simd_sli_unit
    import sli_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [CTRL_W-1:0]  ctrl_field,
    input  logic               quad_sel,
    input  logic               dst_idx_lsb,
    input  logic               src_idx_lsb,
    input  logic [DATA_W-1:0]  src_opnd,
    input  logic [DATA_W-1:0]  dst_old,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result,
    output logic               wr_en,
    output logic               undef_flag,
    output logic               not_op_flag
);
    dec_t              dec;
    logic [DATA_W-1:0] merged;
    out_t              out_d, out_q;

    sli_decode u_dec (
        .ctrl (ctrl_field),
        .dec  (dec)
    );

    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        sli_reg_merge #(.W(REG_W)) u_merge (
            .src   (src_opnd[r*REG_W +: REG_W]),
            .dst   (dst_old[r*REG_W +: REG_W]),
            .size  (dec.size),
            .shamt (dec.shamt),
            .res   (merged[r*REG_W +: REG_W])
        );
    end

    always_comb begin
        logic bad_idx;
        logic blocked;
        bad_idx      = quad_sel & (dst_idx_lsb | src_idx_lsb) & ~dec.not_op;
        blocked      = bad_idx | dec.not_op;
        out_d        = out_q;
        out_d.valid  = in_valid;
        out_d.not_op = in_valid & dec.not_op;
        out_d.undef  = in_valid & bad_idx;
        out_d.wr_en  = in_valid & ~blocked;
        if (in_valid) begin
            if (blocked) begin
                out_d.result = dst_old;
            end else if (quad_sel) begin
                out_d.result = merged;
            end else begin
                out_d.result = {dst_old[DATA_W-1:REG_W], merged[REG_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid   = out_q.valid;
    assign result      = out_q.result;
    assign wr_en       = out_q.wr_en;
    assign undef_flag  = out_q.undef;
    assign not_op_flag = out_q.not_op;
endmodule

// File: rtl/sli_checker.sv
module sli_checker
    import sli_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [CTRL_W-1:0]  ctrl_field,
    input logic               quad_sel,
    input logic               dst_idx_lsb,
    input logic               src_idx_lsb,
    input logic [DATA_W-1:0]  src_opnd,
    input logic [DATA_W-1:0]  dst_old,
    input logic               out_valid,
    input logic [DATA_W-1:0]  result,
    input logic               wr_en,
    input logic               undef_flag,
    input logic               not_op_flag
);
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid))
        else $error("R8 out_valid does not follow in_valid");

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(wr_en || undef_flag || not_op_flag))
        else $error("R8 flag without out_valid");

    assert_wr_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en == (out_valid && !undef_flag && !not_op_flag))
        else $error("R9 write enable rule broken");

    assert_not_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ctrl_field[6:3] == 4'b0000 |=> not_op_flag && !wr_en && result == $past(dst_old))
        else $error("R2 refused pattern handled wrongly");

    assert_undef_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && quad_sel && (dst_idx_lsb || src_idx_lsb) && ctrl_field[6:3] != 4'b0000
        |=> undef_flag && !wr_en && result == $past(dst_old))
        else $error("R7 odd index not refused");

    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(undef_flag && not_op_flag))
        else $error("R7 both refusal flags raised");

    assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !quad_sel |=> result[DATA_W-1:REG_W] == $past(dst_old[DATA_W-1:REG_W]))
        else $error("R6 upper half changed");

    assert_zero_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !quad_sel && ctrl_field == 7'b1000000 |=> result[REG_W-1:0] == $past(src_opnd[REG_W-1:0]))
        else $error("R5 zero shift did not copy source");
endmodule

bind simd_sli_unit sli_checker u_chk (.*);

// File: tb/sim_simd_sli_unit.sv
`timescale 1ns/1ps
module sim_simd_sli_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [6:0]   ctrl_field = '0;
    logic         quad_sel = 1'b0;
    logic         dst_idx_lsb = 1'b0;
    logic         src_idx_lsb = 1'b0;
    logic [127:0] src_opnd = '0;
    logic [127:0] dst_old = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         wr_en;
    logic         undef_flag;
    logic         not_op_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd_sli_unit u0 (.*);

    function automatic int lane_bits(input logic [6:0] c);
        for (int b = 6; b >= 3; b--) begin
            if (c[b]) return 8 << (b - 3);
        end
        return 0;
    endfunction

    function automatic logic [127:0] ref_model(input logic [6:0] c, input logic q,
                                                input logic [127:0] s, input logic [127:0] d);
        logic [127:0] r;
        int es, sh, span, p;
        es   = lane_bits(c);
        sh   = int'(c[5:0]) - ((es == 64) ? 0 : es);
        span = q ? 128 : 64;
        for (int i = 0; i < 128; i++) begin
            p = i % es;
            if (i >= span || p < sh) r[i] = d[i];
            else r[i] = s[i - sh];
        end
        return r;
    endfunction

    task automatic chk_vec(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [6:0] c, input logic q,
                          input logic dl, input logic sl,
                          input logic [127:0] s, input logic [127:0] d);
        logic notop, undef;
        logic [127:0] exp;
        @(negedge clk);
        in_valid = 1'b1; ctrl_field = c; quad_sel = q;
        dst_idx_lsb = dl; src_idx_lsb = sl; src_opnd = s; dst_old = d;
        notop = (c[6:3] == 4'b0000);
        undef = !notop && q && (dl || sl);
        exp   = (notop || undef) ? d : ref_model(c, q, s, d);
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit({tag, " R8 out_valid"}, out_valid, 1'b1);
        chk_vec({tag, " R3 result"}, result, exp);
        chk_bit({tag, " R2 not_op_flag"}, not_op_flag, notop);
        chk_bit({tag, " R7 undef_flag"}, undef_flag, undef);
        chk_bit({tag, " R9 wr_en"}, wr_en, !(notop || undef));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        logic [127:0] ones, s, d;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        ones = '1;
        repeat (3) @(negedge clk);
        chk_bit("R10 reset out_valid", out_valid, 1'b0);
        chk_bit("R10 reset wr_en", wr_en, 1'b0);
        chk_bit("R10 reset flags", undef_flag | not_op_flag, 1'b0);
        chk_vec("R10 reset result", result, '0);
        rst_n = 1'b1;

        // R1 R5 shift 0 and largest shift for every width, both quad settings
        for (int k = 0; k < 4; k++) begin
            for (int q = 0; q < 2; q++) begin
                logic [6:0] c0, cmax;
                c0   = 7'b0001000 << k;
                cmax = c0 | ((7'd8 << k) - 7'd1);
                s = rnd128(); d = rnd128();
                run_op("R5 zero shift", c0, q[0], 1'b0, 1'b0, s, d);
                chk_vec("R5 low lane copy", result[63:0], s[63:0]);
                run_op("R1 max shift", cmax, q[0], 1'b0, 1'b0, s, d);
            end
        end

        // R4 all-ones source at largest shift: only lane top bits change
        run_op("R4 8-bit spill", 7'b0001111, 1'b1, 1'b0, 1'b0, ones, '0);
        chk_vec("R4 8-bit tops only", result, {16{8'h80}});
        run_op("R4 16-bit spill", 7'b0011111, 1'b0, 1'b0, 1'b0, ones, '0);
        chk_vec("R4 16-bit tops only", result, {64'h0, {4{16'h8000}}});

        // R6 upper half kept with single register
        d = rnd128();
        run_op("R6 single reg", 7'b0100011, 1'b0, 1'b1, 1'b1, rnd128(), d);
        chk_vec("R6 upper half", result[127:64], d[127:64]);

        // R2 refused pattern, R7 odd indices
        run_op("R2 not op", 7'b0000101, 1'b1, 1'b1, 1'b0, rnd128(), rnd128());
        run_op("R7 odd dst", 7'b0010010, 1'b1, 1'b1, 1'b0, rnd128(), rnd128());
        run_op("R7 odd src", 7'b1000001, 1'b1, 1'b0, 1'b1, rnd128(), rnd128());

        // R8 idle cycle after an operation
        @(negedge clk);
        chk_bit("R8 idle out_valid", out_valid, 1'b0);
        chk_bit("R8 idle wr_en", wr_en, 1'b0);

        // R3 random mix over the whole control space
        for (int n = 0; n < 400; n++) begin
            logic [3:0] r;
            r = 4'($urandom());
            run_op("R3 random", 7'($urandom()), r[0], r[1] & r[3], r[2] & r[3], rnd128(), rnd128());
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule